// File: doc/BRIEF.md
# 32-bit Integer Instruction Decoder and Datapath Control

This block is a purely combinational decode stage for a single-cycle integer core. It turns one 32-bit instruction word into three register indices, a sign-extended immediate, and the select and enable codes that steer the datapath. The datapath has an operand-1 mux (register or upper immediate), an operand-2 mux (register, store offset, I offset or PC), a writeback mux, and a next-PC mux.

The supported instructions are:
- word load and word store;
- the register-immediate operations add, set-less-than, or, and, and shift-left;
- the register-register operations add, subtract and shift-left;
- upper-immediate load;
- jump-and-link and register-indirect jump-and-link;
- six conditional branches;
- environment call and breakpoint.

Every other encoding raises an illegal flag. An illegal encoding also has all enables and codes forced to zero, so a stray word cannot write state.

The surrounding core feeds the fetched word in and uses the outputs in the same cycle. Branch resolution and jump targets use `br_cond_o` and `pc_sel_o` together with the immediate.

Top module: `rvdec_top`

## Requirements
- R1: `rs1_idx_o`, `rs2_idx_o` and `rd_idx_o` always equal instruction bits 19:15, 24:20 and 11:7, for every word including illegal ones.
- R2: Opcode 0000011 with funct3 010 is a word load. Its outputs are:
  - ALU code 0 (add), op1 code 0, op2 code 2 (I offset);
  - register write 1, writeback code 2 (memory data);
  - immediate = bits 31:20 sign-extended.

  Opcode 0100011 with funct3 010 is a word store. Its outputs are:
  - op2 code 1 (store offset), memory write 1, register write 0, writeback code 0;
  - immediate = {bits 31:25, bits 11:7} sign-extended.
- R3: Opcode 0010011 is a register-immediate operation with op2 code 2, register write 1, writeback code 1 and the I immediate. funct3 selects the ALU code:
  - 000 gives 0 (add);
  - 010 gives 3 (set-less-than);
  - 110 gives 4 (or);
  - 111 gives 5 (and);
  - 001 gives 2 (shift-left), but only when bits 31:25 are zero.
- R4: Opcode 0110011 is a register-register operation with op2 code 0, register write 1, writeback code 1 and immediate 0:
  - funct3 000 with funct7 0000000 gives ALU code 0;
  - funct3 000 with funct7 0100000 gives ALU code 1 (subtract);
  - funct3 001 with funct7 0000000 gives ALU code 2.
- R5: Opcode 0110111 (upper-immediate load) gives:
  - ALU code 6 (pass operand 1), op1 code 1, register write 1, writeback code 1;
  - immediate = {bits 31:12, twelve zeros}.
- R6: Opcode 1101111 (jump-and-link) gives:
  - register write 1, writeback code 0 (PC+4), next-PC code 3;
  - immediate = {bit 31, bits 19:12, bit 20, bits 30:21, 0}, sign-extended.
- R7: Opcode 1100111 with funct3 000 (register-indirect jump-and-link) gives ALU code 0, op2 code 2, register write 1, writeback code 0, next-PC code 1 and the I immediate. Any other funct3 with this opcode is illegal.
- R8: Opcode 1100011 is a conditional branch. Its outputs are:
  - ALU code 1, next-PC code 2, no memory or register write;
  - immediate = {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended;
  - condition code from funct3: 000→1 (eq), 001→2 (ne), 100→3 (lt), 101→4 (ge), 110→5 (ltu), 111→6 (geu).

  funct3 010 and 011 are illegal.
- R9: Opcode 1110011 with bits 19:7 all zero is special:
  - bits 31:20 equal to 0 raise `env_call_o`;
  - bits 31:20 equal to 1 raise `break_o`;
  - every other code and immediate is 0 in both cases;
  - any other word with this opcode is illegal.
- R10: Any encoding not listed in R2 to R9 raises `illegal_o` and drives every other control output and the immediate to 0.
- R11: Immediates are sign-extended from their top bit to the full output width, so a negative offset appears with all upper bits set.
- R12: For every input word:
  - at most one of `env_call_o`, `break_o`, `illegal_o` is high;
  - memory write and register write are never both high;
  - writeback code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| imm_o | output | XLEN | Sign-extended immediate for the decoded format |
| alu_fn_o | output | 3 | ALU function code |
| op1_sel_o | output | 1 | Operand-1 select: 0 register, 1 upper immediate |
| op2_sel_o | output | 2 | Operand-2 select: 0 register, 1 store offset, 2 I offset, 3 PC |
| mem_wr_o | output | 1 | Data memory write enable |
| rf_wen_o | output | 1 | Register file write enable |
| wb_sel_o | output | 2 | Writeback select: 0 PC+4, 1 ALU, 2 memory data |
| pc_sel_o | output | 2 | Next-PC select: 0 sequential, 1 register jump, 2 branch, 3 jump |
| br_cond_o | output | 3 | Branch condition code, 0 when not a branch |
| env_call_o | output | 1 | Environment call decoded |
| break_o | output | 1 | Breakpoint decoded |
| illegal_o | output | 1 | Encoding outside the supported set |

## Verification
Directed words cover each supported instruction with positive and negative offsets. This separates the five immediate layouts and shows that sign extension reaches the top bit. Near-miss words differ from a legal encoding in one field: a wrong funct3, a nonzero funct7 on a shift, a nonzero rd on an environment call. These tell strict decoding apart from a decode that looks at the opcode alone. Pseudo-random words, half with their opcode forced into the supported set, are compared against a behavioural model on every clock to catch field mix-ups that the directed cases miss.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int ILEN      = 32;
    localparam int REG_IDX_W = 5;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    localparam logic [2:0] F3_WORD = 3'b010;
    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_SLL   = 3'd2,
        ALU_SLT   = 3'd3,
        ALU_OR    = 3'd4,
        ALU_AND   = 3'd5,
        ALU_PASS1 = 3'd6
    } alu_fn_e;

    typedef enum logic [0:0] {
        OP1_REG  = 1'b0,
        OP1_UIMM = 1'b1
    } op1_sel_e;

    typedef enum logic [1:0] {
        OP2_REG   = 2'd0,
        OP2_SIMM  = 2'd1,
        OP2_IIMM  = 2'd2,
        OP2_PC    = 2'd3
    } op2_sel_e;

    typedef enum logic [1:0] {
        WB_PC4 = 2'd0,
        WB_ALU = 2'd1,
        WB_MEM = 2'd2
    } wb_sel_e;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_REGJMP = 2'd1,
        PC_BRANCH = 2'd2,
        PC_JUMP   = 2'd3
    } pc_sel_e;

    typedef enum logic [2:0] {
        BR_NONE = 3'd0,
        BR_EQ   = 3'd1,
        BR_NE   = 3'd2,
        BR_LT   = 3'd3,
        BR_GE   = 3'd4,
        BR_LTU  = 3'd5,
        BR_GEU  = 3'd6
    } br_cond_e;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } imm_fmt_e;

    typedef struct packed {
        alu_fn_e  alu_fn;
        op1_sel_e op1;
        op2_sel_e op2;
        logic     mem_wr;
        logic     rf_wen;
        wb_sel_e  wb;
        pc_sel_e  pc;
        br_cond_e br;
        logic     env_call;
        logic     brk;
        logic     illegal;
        imm_fmt_e fmt;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        alu_fn:   ALU_ADD,
        op1:      OP1_REG,
        op2:      OP2_REG,
        mem_wr:   1'b0,
        rf_wen:   1'b0,
        wb:       WB_PC4,
        pc:       PC_SEQ,
        br:       BR_NONE,
        env_call: 1'b0,
        brk:      1'b0,
        illegal:  1'b0,
        fmt:      FMT_NONE
    };

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output ctrl_t           ctrl_o
);

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [11:0] sys_code;
    logic [12:0] sys_mid;
    logic        legal;
    ctrl_t       c;

    always_comb begin
        opc      = instr_i[6:0];
        f3       = instr_i[14:12];
        f7       = instr_i[31:25];
        sys_code = instr_i[31:20];
        sys_mid  = instr_i[19:7];
        c        = CTRL_NOP;
        legal    = 1'b0;

        unique case (opc)
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    legal    = 1'b1;
                    c.op2    = OP2_IIMM;
                    c.rf_wen = 1'b1;
                    c.wb     = WB_MEM;
                    c.fmt    = FMT_I;
                end
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    legal    = 1'b1;
                    c.op2    = OP2_SIMM;
                    c.mem_wr = 1'b1;
                    c.fmt    = FMT_S;
                end
            end
            OPC_OPIMM: begin
                legal    = 1'b1;
                c.op2    = OP2_IIMM;
                c.rf_wen = 1'b1;
                c.wb     = WB_ALU;
                c.fmt    = FMT_I;
                unique case (f3)
                    3'b000:  c.alu_fn = ALU_ADD;
                    3'b010:  c.alu_fn = ALU_SLT;
                    3'b110:  c.alu_fn = ALU_OR;
                    3'b111:  c.alu_fn = ALU_AND;
                    3'b001: begin
                        c.alu_fn = ALU_SLL;
                        legal    = (f7 == F7_BASE);
                    end
                    default: legal = 1'b0;
                endcase
            end
            OPC_OP: begin
                c.rf_wen = 1'b1;
                c.wb     = WB_ALU;
                if (f3 == 3'b000 && f7 == F7_BASE) begin
                    legal    = 1'b1;
                    c.alu_fn = ALU_ADD;
                end else if (f3 == 3'b000 && f7 == F7_ALT) begin
                    legal    = 1'b1;
                    c.alu_fn = ALU_SUB;
                end else if (f3 == 3'b001 && f7 == F7_BASE) begin
                    legal    = 1'b1;
                    c.alu_fn = ALU_SLL;
                end
            end
            OPC_LUI: begin
                legal    = 1'b1;
                c.alu_fn = ALU_PASS1;
                c.op1    = OP1_UIMM;
                c.rf_wen = 1'b1;
                c.wb     = WB_ALU;
                c.fmt    = FMT_U;
            end
            OPC_JAL: begin
                legal    = 1'b1;
                c.rf_wen = 1'b1;
                c.wb     = WB_PC4;
                c.pc     = PC_JUMP;
                c.fmt    = FMT_J;
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    legal    = 1'b1;
                    c.op2    = OP2_IIMM;
                    c.rf_wen = 1'b1;
                    c.wb     = WB_PC4;
                    c.pc     = PC_REGJMP;
                    c.fmt    = FMT_I;
                end
            end
            OPC_BRANCH: begin
                unique case (f3)
                    3'b000:  c.br = BR_EQ;
                    3'b001:  c.br = BR_NE;
                    3'b100:  c.br = BR_LT;
                    3'b101:  c.br = BR_GE;
                    3'b110:  c.br = BR_LTU;
                    3'b111:  c.br = BR_GEU;
                    default: c.br = BR_NONE;
                endcase
                if (c.br != BR_NONE) begin
                    legal    = 1'b1;
                    c.alu_fn = ALU_SUB;
                    c.pc     = PC_BRANCH;
                    c.fmt    = FMT_B;
                end
            end
            OPC_SYSTEM: begin
                if (sys_mid == '0) begin
                    if (sys_code == 12'd0) begin
                        legal      = 1'b1;
                        c.env_call = 1'b1;
                    end else if (sys_code == 12'd1) begin
                        legal = 1'b1;
                        c.brk = 1'b1;
                    end
                end
            end
            default: legal = 1'b0;
        endcase

        if (!legal) begin
            c         = CTRL_NOP;
            c.illegal = 1'b1;
        end
        ctrl_o = c;
    end

endmodule

// File: rtl/rvdec_imm_gen.sv
module rvdec_imm_gen
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);

    logic [ILEN-1:0] imm32;
    logic            sgn;

    always_comb begin
        sgn = instr_i[31];
        unique case (fmt_i)
            FMT_I:   imm32 = {{20{sgn}}, instr_i[31:20]};
            FMT_S:   imm32 = {{20{sgn}}, instr_i[31:25], instr_i[11:7]};
            FMT_B:   imm32 = {{20{sgn}}, instr_i[7], instr_i[30:25],
                              instr_i[11:8], 1'b0};
            FMT_U:   imm32 = {instr_i[31:12], 12'h000};
            FMT_J:   imm32 = {{12{sgn}}, instr_i[19:12], instr_i[20],
                              instr_i[30:21], 1'b0};
            default: imm32 = '0;
        endcase
    end

    if (XLEN > ILEN) begin : g_wide
        assign imm_o = {{(XLEN-ILEN){imm32[ILEN-1]}}, imm32};
    end else begin : g_native
        assign imm_o = imm32[XLEN-1:0];
    end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rs1_idx_o,
    output logic [4:0]      rs2_idx_o,
    output logic [4:0]      rd_idx_o,
    output logic [XLEN-1:0] imm_o,
    output logic [2:0]      alu_fn_o,
    output logic            op1_sel_o,
    output logic [1:0]      op2_sel_o,
    output logic            mem_wr_o,
    output logic            rf_wen_o,
    output logic [1:0]      wb_sel_o,
    output logic [1:0]      pc_sel_o,
    output logic [2:0]      br_cond_o,
    output logic            env_call_o,
    output logic            break_o,
    output logic            illegal_o
);

    ctrl_t ctrl;

    rvdec_ctrl u_ctrl (
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    rvdec_imm_gen #(.XLEN(XLEN)) u_imm (
        .instr_i (instr_i),
        .fmt_i   (ctrl.fmt),
        .imm_o   (imm_o)
    );

    assign rs1_idx_o  = instr_i[19:15];
    assign rs2_idx_o  = instr_i[24:20];
    assign rd_idx_o   = instr_i[11:7];
    assign alu_fn_o   = ctrl.alu_fn;
    assign op1_sel_o  = ctrl.op1;
    assign op2_sel_o  = ctrl.op2;
    assign mem_wr_o   = ctrl.mem_wr;
    assign rf_wen_o   = ctrl.rf_wen;
    assign wb_sel_o   = ctrl.wb;
    assign pc_sel_o   = ctrl.pc;
    assign br_cond_o  = ctrl.br;
    assign env_call_o = ctrl.env_call;
    assign break_o    = ctrl.brk;
    assign illegal_o  = ctrl.illegal;

    always_comb begin
        if (!$isunknown(instr_i)) begin
            assert_illegal_quiet_R10: assert (!illegal_o ||
                (!mem_wr_o && !rf_wen_o && pc_sel_o == 2'd0 && imm_o == '0))
                else $error("illegal word left a control active");
            assert_one_flag_R12: assert ($onehot0({env_call_o, break_o, illegal_o}))
                else $error("more than one decode flag raised");
            assert_no_dual_write_R12: assert (!(mem_wr_o && rf_wen_o))
                else $error("memory and register write together");
            assert_wb_code_R12: assert (wb_sel_o != 2'd3)
                else $error("unused writeback code produced");
            assert_branch_quiet_R8: assert (pc_sel_o != 2'd2 ||
                (!mem_wr_o && !rf_wen_o && br_cond_o != 3'd0))
                else $error("branch with write or without condition");
            assert_even_target_R6: assert (!(pc_sel_o inside {2'd2, 2'd3}) || !imm_o[0])
                else $error("odd relative target offset");
        end
    end

endmodule

// File: tb/rvdec_top_tb_top.sv
`timescale 1ns/1ps
module rvdec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic [2:0]  alu_fn, br;
    logic        op1, mw, rw, ec, eb, il;
    logic [1:0]  op2, wb, pc;
    int          checks = 0;
    int          fails  = 0;

    always #2.5 clk = ~clk;

    rvdec_top dut_i (
        .instr_i    (instr),
        .rs1_idx_o  (rs1),
        .rs2_idx_o  (rs2),
        .rd_idx_o   (rd),
        .imm_o      (imm),
        .alu_fn_o   (alu_fn),
        .op1_sel_o  (op1),
        .op2_sel_o  (op2),
        .mem_wr_o   (mw),
        .rf_wen_o   (rw),
        .wb_sel_o   (wb),
        .pc_sel_o   (pc),
        .br_cond_o  (br),
        .env_call_o (ec),
        .break_o    (eb),
        .illegal_o  (il)
    );

    function automatic logic [31:0] enc_i(int v, int a, int f3, int d, logic [6:0] op);
        logic [31:0] t = v;
        return {t[11:0], 5'(a), 3'(f3), 5'(d), op};
    endfunction

    function automatic logic [31:0] enc_s(int v, int b, int a, int f3, logic [6:0] op);
        logic [31:0] t = v;
        return {t[11:5], 5'(b), 5'(a), 3'(f3), t[4:0], op};
    endfunction

    function automatic logic [31:0] enc_b(int v, int b, int a, int f3);
        logic [31:0] t = v;
        return {t[12], t[10:5], 5'(b), 5'(a), 3'(f3), t[4:1], t[11], 7'h63};
    endfunction

    function automatic logic [31:0] enc_u(int v, int d, logic [6:0] op);
        logic [31:0] t = v;
        return {t[19:0], 5'(d), op};
    endfunction

    function automatic logic [31:0] enc_j(int v, int d);
        logic [31:0] t = v;
        return {t[20], t[10:1], t[11], t[19:12], 5'(d), 7'h6F};
    endfunction

    function automatic logic [31:0] enc_r(int f7, int b, int a, int f3, int d);
        return {7'(f7), 5'(b), 5'(a), 3'(f3), 5'(d), 7'h33};
    endfunction

    // behavioural expectation built from the requirement text
    function automatic logic [64:0] model(logic [31:0] w);
        string       k = "bad";
        logic [31:0] v = '0;
        int alu = 0, o1 = 0, o2 = 0, m = 0, r = 0, b = 0, p = 0, c = 0, e = 0, x = 0, bad = 0;
        logic [6:0] op = w[6:0];
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        if (op == 7'h03 && f3 == 3'd2) k = "load";
        else if (op == 7'h23 && f3 == 3'd2) k = "store";
        else if (op == 7'h63 && f3 != 3'd2 && f3 != 3'd3) k = "branch";
        else if (op == 7'h13 && (f3 == 0 || f3 == 2 || f3 == 6 || f3 == 7)) k = "immop";
        else if (op == 7'h13 && f3 == 1 && f7 == 0) k = "immop";
        else if (op == 7'h33 && f3 == 0 && (f7 == 0 || f7 == 7'h20)) k = "regop";
        else if (op == 7'h33 && f3 == 1 && f7 == 0) k = "regop";
        else if (op == 7'h37) k = "upper";
        else if (op == 7'h6F) k = "jump";
        else if (op == 7'h67 && f3 == 0) k = "rjump";
        else if (op == 7'h73 && w[19:7] == 0 && w[31:20] == 0) k = "env";
        else if (op == 7'h73 && w[19:7] == 0 && w[31:20] == 1) k = "brk";
        case (k)
            "load":   begin o2 = 2; r = 1; b = 2; v = 32'($signed(w[31:20])); end
            "store":  begin o2 = 1; m = 1; v = 32'($signed({w[31:25], w[11:7]})); end
            "branch": begin
                alu = 1; p = 2;
                c = (f3 == 0) ? 1 : (f3 == 1) ? 2 : (f3 == 4) ? 3 :
                    (f3 == 5) ? 4 : (f3 == 6) ? 5 : 6;
                v = 32'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0}));
            end
            "immop":  begin
                alu = (f3 == 0) ? 0 : (f3 == 2) ? 3 : (f3 == 6) ? 4 : (f3 == 7) ? 5 : 2;
                o2 = 2; r = 1; b = 1; v = 32'($signed(w[31:20]));
            end
            "regop":  begin alu = (f3 == 1) ? 2 : (f7 == 0) ? 0 : 1; r = 1; b = 1; end
            "upper":  begin alu = 6; o1 = 1; r = 1; b = 1; v = {w[31:12], 12'h0}; end
            "jump":   begin
                r = 1; p = 3;
                v = 32'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0}));
            end
            "rjump":  begin o2 = 2; r = 1; p = 1; v = 32'($signed(w[31:20])); end
            "env":    e = 1;
            "brk":    x = 1;
            default:  bad = 1;
        endcase
        return {w[19:15], w[24:20], w[11:7], v, 3'(alu), 1'(o1), 2'(o2), 1'(m),
                1'(r), 2'(b), 2'(p), 3'(c), 1'(e), 1'(x), 1'(bad)};
    endfunction

    task automatic apply(logic [31:0] w, string tag);
        logic [64:0] exp_v, act_v;
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
        exp_v = model(w);
        act_v = {rs1, rs2, rd, imm, alu_fn, op1, op2, mw, rw, wb, pc, br, ec, eb, il};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, act_v, exp_v);
        end
    endtask

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1234_5679;
        logic [6:0]  ops [9] = '{7'h03, 7'h23, 7'h63, 7'h13, 7'h33, 7'h37, 7'h6F, 7'h67, 7'h73};
        repeat (3) @(posedge clk);
        apply(32'h0000_0000, "R10 reset word");
        rst = 1'b0;
        // R1 raw register fields
        apply(enc_r(0, 17, 31, 0, 1), "R1 fields add");
        apply(32'hFFFF_FFFF, "R1 R10 all ones");
        // R2 load and store
        apply(enc_i(-4, 2, 2, 5, 7'h03), "R2 load neg");
        apply(enc_i(2047, 9, 2, 6, 7'h03), "R2 load pos");
        apply(enc_s(2044, 7, 3, 2, 7'h23), "R2 store pos");
        apply(enc_s(-2048, 7, 3, 2, 7'h23), "R11 store min");
        apply(enc_i(0, 2, 0, 5, 7'h03), "R10 byte load");
        // R3 register-immediate operations
        apply(enc_i(-1, 4, 0, 8, 7'h13), "R3 addi");
        apply(enc_i(100, 4, 2, 8, 7'h13), "R3 slti");
        apply(enc_i(12'h0F0, 4, 6, 8, 7'h13), "R3 ori");
        apply(enc_i(-256, 4, 7, 8, 7'h13), "R3 andi");
        apply(enc_i(5, 4, 1, 8, 7'h13), "R3 slli");
        apply(enc_i(12'h405, 4, 1, 8, 7'h13), "R10 slli f7");
        apply(enc_i(3, 4, 3, 8, 7'h13), "R10 sltiu");
        // R4 register-register operations
        apply(enc_r(0, 3, 2, 0, 1), "R4 add");
        apply(enc_r(32, 3, 2, 0, 1), "R4 sub");
        apply(enc_r(0, 3, 2, 1, 1), "R4 sll");
        apply(enc_r(1, 3, 2, 0, 1), "R10 bad funct7");
        apply(enc_r(0, 3, 2, 4, 1), "R10 xor");
        // R5 upper immediate
        apply(enc_u(20'hFFFFF, 10, 7'h37), "R5 upper all ones");
        apply(enc_u(20'h12345, 11, 7'h37), "R5 upper");
        apply(enc_u(20'h12345, 11, 7'h17), "R10 pc-upper");
        // R6 jump
        apply(enc_j(2048, 1), "R6 jump pos");
        apply(enc_j(-4, 1), "R11 jump neg");
        apply(enc_j(20'hFFFFE, 0), "R6 jump far");
        // R7 register jump
        apply(enc_i(-12, 5, 0, 1, 7'h67), "R7 rjump");
        apply(enc_i(8, 5, 1, 1, 7'h67), "R7 rjump bad f3");
        // R8 branches
        for (int f = 0; f < 8; f++) begin
            apply(enc_b(-16, 6, 7, f), "R8 branch neg");
            apply(enc_b(4094, 6, 7, f), "R8 branch pos");
        end
        // R9 system
        apply(32'h0000_0073, "R9 env call");
        apply(32'h0010_0073, "R9 breakpoint");
        apply(32'h0000_00F3, "R9 env nonzero rd");
        apply(32'h0000_1073, "R9 csr form");
        apply(32'h0020_0073, "R9 other code");
        // R12 random sweep
        for (int n = 0; n < 400; n++) begin
            lf ^= lf << 13;
            lf ^= lf >> 17;
            lf ^= lf << 5;
            if (n[0]) apply({lf[31:7], ops[lf[3:0] % 9]}, "R12 random legal-op");
            else      apply(lf, "R12 random word");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule